// File: doc/BRIEF.md
# Programmable-Header Serial Frame Aligner

This block sits behind a one-bit serial receiver and runs on the serial bit clock. It keeps the last 32 received bits in a window and compares that window with a programmable header pattern. A per-bit mask selects which window positions take part in the comparison, so headers shorter than 32 bits (for example a 10-bit pattern) can sit anywhere in the 32-bit register. The header's position in the register decides where the 4-bit word boundary falls. When the header is found, the block aligns its nibble output so that window positions 15..12 come out as one nibble, and it marks that nibble with a frame pulse.

After that it delivers one nibble every four bit clocks, with a one-clock strobe for each new nibble. A parity bit goes with every nibble. Parity is even by default. It can be switched to odd, or turned off so that the output stays at zero. The alignment enable input decides when a new boundary may be taken. While the enable is low, the current boundary is kept, and a header that recurs on that boundary still produces a frame pulse.

Top module: `frame_aligner`

## Requirements
- R1: During and right after reset, nibOut, nibStrobe, framePulse and parOut are all 0.
- R2: The window holds the last 32 sampled bits, with bit 31 the oldest and bit 0 the newest. A header match needs window bit i to equal hdrPattern bit i for every i where hdrMask bit i is 1. Bits where the mask is 0 have no effect.
- R3: Suppose alignEn is 1 and a match is present after bit clock edge X. Then after edge X+1, nibStrobe is 1, framePulse is 1, and nibOut holds window bits 15..12 as they stood after edge X. With a full mask over those bits, this nibble equals hdrPattern[15:12].
- R4: Once aligned, nibStrobe pulses for one clock every fourth clock. Each new nibble is the next four received bits, with the earliest bit in nibOut[3]. Finding a new boundary restarts this four-clock period from the new strobe.
- R5: framePulse changes only when a new nibble is loaded. It stays high for exactly the one nibble (four clocks) that carries the header, and it is low on nibbles loaded without a match.
- R6: While alignEn is 0, a match that does not fall on the current boundary is ignored: no strobe is added and no pulse is given. A match that falls on the current boundary still raises framePulse.
- R7: Before the first alignment, nibStrobe stays 0 and nibOut stays 0.
- R8: With parEn=1 and parOdd=0, parOut is the XOR of the four bits of nibOut (even parity).
- R9: With parEn=1 and parOdd=1, parOut is the inverse of that XOR (odd parity). A change to parOdd applies to the nibble already on the output.
- R10: With parEn=0, parOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial data, sampled on each rising edge |
| hdrPattern | input | 32 | Header pattern, with bit 31 received first |
| hdrMask | input | 32 | Compare mask; 1 = this bit takes part |
| alignEn | input | 1 | Allows a new word boundary to be taken |
| parOdd | input | 1 | 1 selects odd parity |
| parEn | input | 1 | 1 enables the parity output |
| nibOut | output | 4 | Aligned parallel nibble |
| nibStrobe | output | 1 | One-clock pulse when a new nibble is loaded |
| framePulse | output | 1 | High for the nibble that carries header bits 15..12 |
| parOut | output | 1 | Parity of nibOut, or 0 when disabled |

## Verification
The bench checks that an aligned stream gives the following nibble four clocks later and that no strobe appears in between. A design that captured on the wrong phase, or with its bits reversed, would show the wrong nibble. It sends the header again with alignEn low, once on the current boundary and once off it. A design that realigned without permission, or that gated the pulse on the enable, would fail one of these two cases. Masked vectors carry junk outside the mask, which exposes a compare that ignores the mask. Parity settings are changed while a nibble is being held, which catches a parity that is sampled only at load time.

// File: rtl/fa_pkg.sv
package fa_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load a new nibble this clock
    logic realign;  // a new boundary is taken this clock
  } faCtl_t;
endpackage

// File: rtl/fa_datapath.sv
module fa_datapath
  import fa_pkg::*;
#(
  parameter int HDR_W     = 32,
  parameter int NIB_W     = 4,
  parameter int SLICE_LSB = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic [HDR_W-1:0] hdrPattern,
  input  logic [HDR_W-1:0] hdrMask,
  input  faCtl_t           ctl,
  input  logic             parOdd,
  input  logic             parEn,
  output logic             hdrMatch,
  output logic [NIB_W-1:0] nibOut,
  output logic             framePulse,
  output logic             parOut
);
  localparam int SLICE_MSB = SLICE_LSB + NIB_W - 1;

  logic [HDR_W-1:0] shReg;
  logic [HDR_W-1:0] bitMiss;
  logic [NIB_W-1:0] nibReg;
  logic             frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[HDR_W-2:0], serIn};
  end

  // Per-bit masked compare
  for (genvar i = 0; i < HDR_W; i++) begin : g_cmp
    assign bitMiss[i] = hdrMask[i] & (shReg[i] ^ hdrPattern[i]);
  end
  assign hdrMatch = ~|bitMiss;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibReg   <= '0;
      frameReg <= 1'b0;
    end else if (ctl.capture) begin
      nibReg   <= shReg[SLICE_MSB:SLICE_LSB];
      frameReg <= hdrMatch;
    end
  end

  assign nibOut     = nibReg;
  assign framePulse = frameReg;
  assign parOut     = parEn & ((^nibReg) ^ parOdd);

  // R5: outputs only move on a capture
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(nibOut) && $stable(framePulse)));

  // R3: a fully compared slice comes out equal to the pattern slice
  p_frame_slice_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && hdrMatch && (&hdrMask[SLICE_MSB:SLICE_LSB]))
      |=> (framePulse && nibOut == $past(hdrPattern[SLICE_MSB:SLICE_LSB])));

  // R8/R9: nibble plus parity bit has the selected sense
  p_parity_sense_r9: assert property (@(posedge clk) disable iff (!rstN)
    parEn |-> ((^{nibOut, parOut}) == parOdd));

  // R10: disabled parity stays low
  p_parity_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !parEn |-> !parOut);
endmodule

// File: rtl/fa_control.sv
module fa_control
  import fa_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   alignEn,
  input  logic   hdrMatch,
  output faCtl_t ctl,
  output logic   nibStrobe
);
  localparam int CNT_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(NIB_W - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             locked;

  always_comb begin
    ctl.realign = alignEn & hdrMatch;
    ctl.capture = ctl.realign | (locked & (phaseCnt == LAST_PH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      locked    <= 1'b0;
      nibStrobe <= 1'b0;
    end else begin
      phaseCnt  <= ctl.capture ? '0 : phaseCnt + 1'b1;
      locked    <= locked | ctl.realign;
      nibStrobe <= ctl.capture;
    end
  end

  // R7: no strobe before the first boundary
  p_no_strobe_unlocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> !nibStrobe);

  // R3: taking a boundary gives a strobe on the next clock
  p_realign_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.realign |=> nibStrobe);

  // R4: strobes are never back to back unless realigned
  p_strobe_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (nibStrobe && !ctl.realign) |=> !nibStrobe);
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import fa_pkg::*;
#(
  parameter int HDR_W     = 32,
  parameter int NIB_W     = 4,
  parameter int SLICE_LSB = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic [HDR_W-1:0] hdrPattern,
  input  logic [HDR_W-1:0] hdrMask,
  input  logic             alignEn,
  input  logic             parOdd,
  input  logic             parEn,
  output logic [NIB_W-1:0] nibOut,
  output logic             nibStrobe,
  output logic             framePulse,
  output logic             parOut
);
  faCtl_t ctl;
  logic   hdrMatch;

  fa_control #(.NIB_W(NIB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .alignEn(alignEn), .hdrMatch(hdrMatch),
    .ctl(ctl), .nibStrobe(nibStrobe)
  );

  fa_datapath #(.HDR_W(HDR_W), .NIB_W(NIB_W), .SLICE_LSB(SLICE_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .hdrPattern(hdrPattern),
    .hdrMask(hdrMask), .ctl(ctl), .parOdd(parOdd), .parEn(parEn),
    .hdrMatch(hdrMatch), .nibOut(nibOut), .framePulse(framePulse),
    .parOut(parOut)
  );
endmodule

// File: tb/tb_frame_aligner.sv
module tb_frame_aligner;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] stream;
    logic [31:0] pattern;
    logic [31:0] mask;
    logic        en;
    logic        odd;
    logic        pen;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{32'hF6F62828, 32'hF6F62828, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1},
    '{32'h1234B5D5, 32'hFFFFB5C0, 32'h0000FFC0, 1'b1, 1'b1, 1'b1},
    '{32'h12347000, 32'h00007000, 32'h0000F000, 1'b1, 1'b0, 1'b0},
    '{32'hF6F62828, 32'hF6F62828, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b1},
    '{32'h00009000, 32'h00009000, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1}
  };
  localparam logic [31:0] HDR = 32'hF6F62828;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic [31:0] hdrPattern = '0;
  logic [31:0] hdrMask = '0;
  logic alignEn = 1'b0, parOdd = 1'b0, parEn = 1'b0;
  logic [3:0] nibOut;
  logic nibStrobe, framePulse, parOut;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_aligner dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .hdrPattern(hdrPattern),
    .hdrMask(hdrMask), .alignEn(alignEn), .parOdd(parOdd), .parEn(parEn),
    .nibOut(nibOut), .nibStrobe(nibStrobe), .framePulse(framePulse),
    .parOut(parOut)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic stepBit(logic b);
    serIn = b;
    @(negedge clk);
  endtask

  task automatic sendWord(logic [31:0] w);
    for (int i = 31; i >= 0; i--) stepBit(w[i]);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    serIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    // R1: reset state
    doReset();
    check("R1", "nibOut", 32'(nibOut), 0);
    check("R1", "nibStrobe", 32'(nibStrobe), 0);
    check("R1", "framePulse", 32'(framePulse), 0);
    check("R1", "parOut", 32'(parOut), 0);

    // Vector table: R2 masks, R3 capture, R7 no enable, R8/R9/R10 parity
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] eNib;
      logic       eStb, eFp, ePar;
      hdrPattern = VECS[v].pattern;
      hdrMask    = VECS[v].mask;
      alignEn    = VECS[v].en;
      parOdd     = VECS[v].odd;
      parEn      = VECS[v].pen;
      doReset();
      sendWord(VECS[v].stream);
      stepBit(1'b0);
      eStb = VECS[v].en;
      eFp  = VECS[v].en;
      eNib = VECS[v].en ? VECS[v].stream[15:12] : 4'h0;
      ePar = VECS[v].pen & ((^eNib) ^ VECS[v].odd);
      check(VECS[v].en ? "R3" : "R7", "vec strobe", 32'(nibStrobe), 32'(eStb));
      check(VECS[v].en ? "R2" : "R7", "vec frame", 32'(framePulse), 32'(eFp));
      check(VECS[v].en ? "R3" : "R7", "vec nibble", 32'(nibOut), 32'(eNib));
      check(VECS[v].pen ? (VECS[v].odd ? "R9" : "R8") : "R10", "vec parity",
            32'(parOut), 32'(ePar));
    end

    // Directed: nibble sequence, pulse length, enable hold, realign
    hdrPattern = HDR; hdrMask = '1; alignEn = 1'b1; parOdd = 1'b0; parEn = 1'b1;
    doReset();
    sendWord(HDR);
    stepBit(1'b0);
    check("R3", "lock strobe", 32'(nibStrobe), 1);
    check("R3", "lock nibble", 32'(nibOut), 32'h2);
    check("R8", "even parity", 32'(parOut), 1);
    stepBit(1'b0);
    check("R4", "no strobe mid nibble", 32'(nibStrobe), 0);
    check("R5", "pulse held", 32'(framePulse), 1);
    stepBit(1'b0);
    stepBit(1'b0);
    check("R5", "pulse held to end", 32'(framePulse), 1);
    stepBit(1'b0);
    check("R4", "next strobe", 32'(nibStrobe), 1);
    check("R4", "next nibble", 32'(nibOut), 32'h8);
    check("R5", "pulse dropped", 32'(framePulse), 0);

    // R6: enable low, header on current boundary
    alignEn = 1'b0;
    repeat (3) stepBit(1'b0);
    sendWord(HDR);
    stepBit(1'b0);
    check("R6", "held boundary strobe", 32'(nibStrobe), 1);
    check("R6", "held boundary pulse", 32'(framePulse), 1);
    check("R6", "held boundary nibble", 32'(nibOut), 32'h2);

    // R6: enable low, header off boundary is ignored
    sendWord(HDR);
    stepBit(1'b0);
    check("R6", "off boundary strobe", 32'(nibStrobe), 0);
    check("R6", "off boundary pulse", 32'(framePulse), 0);

    // R4: enable high, header off boundary realigns
    alignEn = 1'b1;
    sendWord(HDR);
    stepBit(1'b0);
    check("R3", "realign strobe", 32'(nibStrobe), 1);
    check("R3", "realign pulse", 32'(framePulse), 1);
    stepBit(1'b0);
    stepBit(1'b0);
    stepBit(1'b0);
    check("R4", "realigned gap", 32'(nibStrobe), 0);
    stepBit(1'b0);
    check("R4", "realigned period", 32'(nibStrobe), 1);
    check("R4", "realigned nibble", 32'(nibOut), 32'h8);

    // R9, R10: parity settings act on the held nibble
    parOdd = 1'b1;
    #1;
    check("R9", "odd on held nibble", 32'(parOut), 0);
    parEn = 1'b0;
    #1;
    check("R10", "parity off", 32'(parOut), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule